// File: doc/BRIEF.md
# Three-Phase Sine Stimulus Source with Zero-Crossing Strobes

This block stands in for mains voltage when converter control logic is tested. It produces three signed sample streams, phase A, phase B and phase C, that are one third of a cycle apart. It also produces, for each phase, one strobe for an upward zero crossing and one for a downward zero crossing. Firing-angle and timing logic can be fed from these outputs directly, with no analog front end.

A single constant table holds one full sine period. Each phase has its own pointer into that table. A free-running prescaler produces a step tick, and on every tick each pointer reads its entry into a sample register and then moves to the next entry. The crossing detector keeps the previous sample of each phase. On the cycle after a step it compares the sign of the previous sample with the sign of the new one, and a sign change starts a strobe of fixed width.

Table entry k holds round(AMP·sin(2π(k+1)/N)), computed with an integer rational approximation when the design is elaborated. With the defaults (N = 400, AMP = 1241, 12-bit samples, a step every 5,000 clocks) the source runs at 50 Hz from a 100 MHz clock.

Top module: `three_phase_sine_src`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, all three samples read 0 and all six strobes are low. A reset that arrives during a strobe clears it. After reset the phase pointers restart at entries 0 (A), OFS_B = 133 (B) and OFS_C = 266 (C).
- R2: Step n (n ≥ 1) loads the samples on clock edge n·TICK_DIV after reset release. Between steps every sample holds its value.
- R3: At step n, phase A shows table entry (n−1) mod N. Entries 0..N/2−2 are positive, entries N/2..N−2 are negative, and entries N/2−1 and N−1 are exactly 0.
- R4: Entries N/4−1 and 3N/4−1 are exactly +AMP and −AMP. Every other entry lies within a few LSB of AMP·sin(2π(k+1)/N).
- R5: At step n, phase B shows entry (OFS_B+n−1) mod N and phase C shows entry (OFS_C+n−1) mod N.
- R6: A pointer at entry N−1 moves to entry 0 on the next step.
- R7: `rise_o[p]` (bit 0 = A, 1 = B, 2 = C) goes high when the new sample of phase p is ≥ 0 and the previous one was negative. This happens only when entry N−1 is loaded. The strobe is high for exactly PULSE_W = 2 clocks, after edges n·TICK_DIV+1 and n·TICK_DIV+2.
- R8: `fall_o[p]` behaves in the same way for a new sample < 0 after a previous sample ≥ 0. This happens only when entry N/2 is loaded.
- R9: Each step is compared once, so a held sample never strobes again. A strobe is low at every other time, and `rise_o[p]` and `fall_o[p]` are never high together.
- R10: The first step after reset compares against the cleared sample value and produces no strobe. Phase C, which starts on a negative entry, therefore shows no falling strobe at step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_a_o | output | W (12) | Phase A sample, two's complement |
| sample_b_o | output | W (12) | Phase B sample, two's complement |
| sample_c_o | output | W (12) | Phase C sample, two's complement |
| rise_o | output | 3 | Upward crossing strobes, bit 0 = A, 1 = B, 2 = C |
| fall_o | output | 3 | Downward crossing strobes, same bit order |

## Verification
The bound checker watches, on every cycle:
- that the samples hold between step ticks;
- that each strobe is no longer than PULSE_W and, when PULSE_W ≥ 2, no shorter than two clocks;
- that a rising or falling strobe starts only after the matching sign change across the last step;
- that the two directions of a phase are never high together;
- that each pointer stays inside the table.

Only the bench scenarios can show the table values and their peaks and zeros, the one-third phase spacing, the wrap, the exact cycle each strobe starts, and the silent first step after a mid-strobe reset.

// File: rtl/sine3_pkg.sv
package sine3_pkg;

    localparam int unsigned PHASES = 3;

    // Signed entry k of one sine period of n entries, amplitude amp.
    // The value follows sin(2*pi*(k+1)/n) through a rational approximation
    // over each half period: 16*q / (5*h*h - 4*q), with q = p*(h-p).
    // The result is exact at the quarter, half and full period points.
    function automatic int sine_entry(input int k, input int n, input int amp);
        int h;
        int p;
        int q;
        int num;
        int den;
        int mag;
        h = n / 2;
        p = (k < h) ? (k + 1) : (k + 1 - h);
        q = p * (h - p);
        num = amp * 16 * q;
        den = 5 * h * h - 4 * q;
        mag = (num + den / 2) / den;
        return (k < h) ? mag : -mag;
    endfunction

endpackage

// File: rtl/sine_tick_div.sv
module sine_tick_div #(
    parameter int unsigned DIV = 5000,
    parameter int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick_o = (st_q.cnt == LAST);
        if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sine_pulse_stretch.sv
module sine_pulse_stretch #(
    parameter int unsigned PULSE_W = 2,
    parameter int unsigned CW      = $clog2(PULSE_W + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic pulse_o
);
    typedef struct packed {
        logic [CW-1:0] left;
    } ps_t;

    ps_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.left = CW'(PULSE_W);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - CW'(1);
        end
        pulse_o = (st_q.left != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sine_phase_lane.sv
module sine_phase_lane #(
    parameter int unsigned N       = 400,
    parameter int unsigned W       = 12,
    parameter int unsigned START   = 0,
    parameter int unsigned PULSE_W = 2,
    parameter int unsigned AW      = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic signed [W-1:0] rd_data_i,
    output logic [AW-1:0]       rd_addr_o,
    output logic signed [W-1:0] sample_o,
    output logic                rise_o,
    output logic                fall_o
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [W-1:0]  cur;
        logic [W-1:0]  prv;
        logic          eval;
        logic          armed;
    } lane_t;

    localparam logic [AW-1:0] PTR_LAST = AW'(N - 1);
    localparam logic [AW-1:0] PTR_INIT = AW'(START);
    localparam lane_t LANE_RST = '{ptr: PTR_INIT, cur: '0, prv: '0,
                                   eval: 1'b0, armed: 1'b0};

    lane_t st_d, st_q;
    logic  rise_det;
    logic  fall_det;

    always_comb begin
        st_d = st_q;
        st_d.eval = tick_i;
        if (tick_i) begin
            st_d.prv = st_q.cur;
            st_d.cur = rd_data_i;
            st_d.ptr = (st_q.ptr == PTR_LAST) ? '0 : st_q.ptr + AW'(1);
        end
        // The first compared step after reset only arms the detector.
        if (st_q.eval) begin
            st_d.armed = 1'b1;
        end
        rise_det = st_q.eval && st_q.armed && !st_q.cur[W-1] && st_q.prv[W-1];
        fall_det = st_q.eval && st_q.armed && st_q.cur[W-1] && !st_q.prv[W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LANE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr_o = st_q.ptr;
    assign sample_o  = st_q.cur;

    sine_pulse_stretch #(.PULSE_W(PULSE_W)) u_rise (
        .clk    (clk),
        .rst    (rst),
        .fire_i (rise_det),
        .pulse_o(rise_o)
    );

    sine_pulse_stretch #(.PULSE_W(PULSE_W)) u_fall (
        .clk    (clk),
        .rst    (rst),
        .fire_i (fall_det),
        .pulse_o(fall_o)
    );
endmodule

// File: rtl/three_phase_sine_src.sv
module three_phase_sine_src #(
    parameter int unsigned N        = 400,
    parameter int unsigned AMP      = 1241,
    parameter int unsigned W        = 12,
    parameter int unsigned TICK_DIV = 5000,
    parameter int unsigned OFS_B    = 133,
    parameter int unsigned OFS_C    = 266,
    parameter int unsigned PULSE_W  = 2
) (
    input  logic                clk,
    input  logic                rst,
    output logic signed [W-1:0] sample_a_o,
    output logic signed [W-1:0] sample_b_o,
    output logic signed [W-1:0] sample_c_o,
    output logic [2:0]          rise_o,
    output logic [2:0]          fall_o
);
    import sine3_pkg::*;

    localparam int unsigned AW = $clog2(N);

    logic                step_tick;
    logic signed [W-1:0] rom     [N];
    logic [AW-1:0]       rd_addr [PHASES];
    logic signed [W-1:0] rd_data [PHASES];
    logic signed [W-1:0] smp     [PHASES];

    // One constant period, shared by all three read ports.
    for (genvar k = 0; k < N; k++) begin : g_rom
        assign rom[k] = W'(sine_entry(k, int'(N), int'(AMP)));
    end

    sine_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst   (rst),
        .tick_o(step_tick)
    );

    for (genvar g = 0; g < PHASES; g++) begin : g_lane
        localparam int unsigned LSTART = (g == 0) ? 0 : ((g == 1) ? OFS_B : OFS_C);

        assign rd_data[g] = rom[rd_addr[g]];

        sine_phase_lane #(
            .N      (N),
            .W      (W),
            .START  (LSTART),
            .PULSE_W(PULSE_W)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .tick_i   (step_tick),
            .rd_data_i(rd_data[g]),
            .rd_addr_o(rd_addr[g]),
            .sample_o (smp[g]),
            .rise_o   (rise_o[g]),
            .fall_o   (fall_o[g])
        );
    end

    assign sample_a_o = smp[0];
    assign sample_b_o = smp[1];
    assign sample_c_o = smp[2];
endmodule

// File: rtl/sine_src_checker.sv
module sine_src_checker #(
    parameter int unsigned N       = 400,
    parameter int unsigned W       = 12,
    parameter int unsigned PULSE_W = 2,
    parameter int unsigned AW      = $clog2(N),
    parameter int unsigned RW      = $clog2(PULSE_W + 2)
) (
    input logic                clk,
    input logic                rst,
    input logic                step_tick,
    input logic signed [W-1:0] smp_a,
    input logic signed [W-1:0] smp_b,
    input logic signed [W-1:0] smp_c,
    input logic [2:0]          rise,
    input logic [2:0]          fall,
    input logic [AW-1:0]       ptr_a,
    input logic [AW-1:0]       ptr_b,
    input logic [AW-1:0]       ptr_c
);
    logic signed [W-1:0] smp [3];
    logic [AW-1:0]       ptr [3];
    logic [RW-1:0]       rise_run [3];
    logic [RW-1:0]       fall_run [3];

    assign smp[0] = smp_a;
    assign smp[1] = smp_b;
    assign smp[2] = smp_c;
    assign ptr[0] = ptr_a;
    assign ptr[1] = ptr_b;
    assign ptr[2] = ptr_c;

    for (genvar g = 0; g < 3; g++) begin : g_chk
        // Length of the current high run on each strobe, counted here.
        always_ff @(posedge clk) begin
            if (rst) begin
                rise_run[g] <= '0;
                fall_run[g] <= '0;
            end else begin
                rise_run[g] <= rise[g] ? ((rise_run[g] == RW'(PULSE_W + 1)) ? rise_run[g] : rise_run[g] + RW'(1)) : '0;
                fall_run[g] <= fall[g] ? ((fall_run[g] == RW'(PULSE_W + 1)) ? fall_run[g] : fall_run[g] + RW'(1)) : '0;
            end
        end

        p_hold_between_steps_r2: assert property (@(posedge clk) disable iff (rst)
            !step_tick |=> $stable(smp[g]));

        p_rise_max_width_r7: assert property (@(posedge clk) disable iff (rst)
            rise[g] |-> rise_run[g] < RW'(PULSE_W));

        p_fall_max_width_r8: assert property (@(posedge clk) disable iff (rst)
            fall[g] |-> fall_run[g] < RW'(PULSE_W));

        if (PULSE_W >= 2) begin : g_min
            p_rise_min_width_r7: assert property (@(posedge clk) disable iff (rst)
                $rose(rise[g]) |=> rise[g]);
            p_fall_min_width_r8: assert property (@(posedge clk) disable iff (rst)
                $rose(fall[g]) |=> fall[g]);
        end

        p_rise_after_sign_up_r7: assert property (@(posedge clk) disable iff (rst)
            $rose(rise[g]) |-> !smp[g][W-1] && $past(smp[g][W-1], 2));

        p_fall_after_sign_down_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(fall[g]) |-> smp[g][W-1] && !$past(smp[g][W-1], 2));

        p_dir_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
            !(rise[g] && fall[g]));

        p_ptr_in_table_r6: assert property (@(posedge clk) disable iff (rst)
            ptr[g] < AW'(N));
    end
endmodule

bind three_phase_sine_src sine_src_checker #(
    .N      (N),
    .W      (W),
    .PULSE_W(PULSE_W),
    .AW     (AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step_tick(step_tick),
    .smp_a    (sample_a_o),
    .smp_b    (sample_b_o),
    .smp_c    (sample_c_o),
    .rise     (rise_o),
    .fall     (fall_o),
    .ptr_a    (rd_addr[0]),
    .ptr_b    (rd_addr[1]),
    .ptr_c    (rd_addr[2])
);

// File: tb/tb_three_phase_sine_src.sv
module tb_three_phase_sine_src;
    localparam int N     = 400;
    localparam int AMP   = 1241;
    localparam int W     = 12;
    localparam int D     = 4;
    localparam int OFS_B = 133;
    localparam int OFS_C = 266;
    localparam int TOL   = 4;
    localparam real PI   = 3.14159265358979;

    // Vector table: step count, expected phase A value, tolerance.
    localparam int VEC_N = 8;
    localparam int VSTEP [VEC_N] = '{1,  50,  100,  200, 201,  300,   400, 401};
    localparam int VEXP  [VEC_N] = '{19, 878, 1241, 0,   -19, -1241, 0,   19};
    localparam int VTOL  [VEC_N] = '{3,  3,   0,    0,   3,    0,     0,   3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [W-1:0] sample_a, sample_b, sample_c;
    logic [2:0] rise, fall;

    int  n_chk = 0;
    int  n_bad = 0;
    int  e     = 0;
    bit  mon   = 1'b0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    three_phase_sine_src #(
        .N(N), .AMP(AMP), .W(W), .TICK_DIV(D),
        .OFS_B(OFS_B), .OFS_C(OFS_C), .PULSE_W(2)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .sample_a_o(sample_a),
        .sample_b_o(sample_b),
        .sample_c_o(sample_c),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    function automatic int ref_val(input int k);
        real r;
        r = AMP * $sin(2.0 * PI * (k + 1) / N);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    function automatic int sign_of_idx(input int k);
        if (k == N / 2 - 1 || k == N - 1) return 0;
        return (k < N / 2 - 1) ? 1 : -1;
    endfunction

    function automatic int sgn(input int v);
        return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
    endfunction

    function automatic int start_of(input int ph);
        return (ph == 0) ? 0 : ((ph == 1) ? OFS_B : OFS_C);
    endfunction

    function automatic int get_smp(input int ph);
        if (ph == 0) return int'(sample_a);
        if (ph == 1) return int'(sample_b);
        return int'(sample_c);
    endfunction

    // Expected outputs after edge e of the run since reset release.
    task automatic check_cycle();
        int n;
        int m;
        n = e / D;
        m = e % D;
        for (int ph = 0; ph < 3; ph++) begin
            int    idx;
            int    act;
            int    exp_v;
            int    sg;
            bit    ok;
            bit    er;
            bit    ef;
            string tag;
            idx = (start_of(ph) + n - 1 + N) % N;
            act = get_smp(ph);
            if (n == 0) begin
                exp_v = 0; sg = 0; tag = "R1";
            end else begin
                exp_v = ref_val(idx); sg = sign_of_idx(idx);
                tag = (m != 0) ? "R2" : ((ph == 0) ? "R3" : "R5");
            end
            ok = (act >= exp_v - TOL) && (act <= exp_v + TOL) && (sgn(act) == sg);
            n_chk++;
            if (!ok) begin
                n_bad++;
                $display("FAIL %s phase %0d edge %0d sample act=%0d exp=%0d", tag, ph, e, act, exp_v);
            end
            er = (n >= 2) && (m == 1 || m == 2) && (idx == N - 1);
            ef = (n >= 2) && (m == 1 || m == 2) && (idx == N / 2);
            n_chk++;
            if (rise[ph] !== er) begin
                n_bad++;
                tag = er ? "R7" : ((n == 1) ? "R10" : "R9");
                $display("FAIL %s phase %0d edge %0d rise act=%0b exp=%0b", tag, ph, e, rise[ph], er);
            end
            n_chk++;
            if (fall[ph] !== ef) begin
                n_bad++;
                tag = ef ? "R8" : ((n == 1) ? "R10" : "R9");
                $display("FAIL %s phase %0d edge %0d fall act=%0b exp=%0b", tag, ph, e, fall[ph], ef);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (mon) begin
            e++;
            check_cycle();
        end
    endtask

    task automatic run_to(input int target);
        while (e < target) tick();
    endtask

    task automatic check_idle(input string what);
        n_chk++;
        if (sample_a !== 0 || sample_b !== 0 || sample_c !== 0 || rise !== 3'b000 || fall !== 3'b000) begin
            n_bad++;
            $display("FAIL R1 %s act=%0d/%0d/%0d r=%b f=%b exp=0/0/0 r=000 f=000",
                     what, sample_a, sample_b, sample_c, rise, fall);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog expired act=running exp=finished");
            report();
            $finish;
        end
    end

    initial begin
        // R1: state held in reset.
        repeat (3) tick();
        check_idle("in reset");
        rst = 1'b0;
        e = 0;
        mon = 1'b1;

        // R4, R6: table values of phase A at chosen steps; monitor runs alongside.
        for (int v = 0; v < VEC_N; v++) begin
            int act;
            run_to(VSTEP[v] * D);
            act = int'(sample_a);
            n_chk++;
            if (act < VEXP[v] - VTOL[v] || act > VEXP[v] + VTOL[v]) begin
                n_bad++;
                $display("FAIL %s step %0d value act=%0d exp=%0d", (VSTEP[v] > N) ? "R6" : "R4",
                         VSTEP[v], act, VEXP[v]);
            end
        end

        // R7: phase C rising strobe is high, then R1: reset clears it.
        run_to(534 * D + 1);
        n_chk++;
        if (rise[2] !== 1'b1) begin
            n_bad++;
            $display("FAIL R7 phase 2 rise before reset act=%0b exp=1", rise[2]);
        end
        rst = 1'b1;
        mon = 1'b0;
        tick();
        check_idle("mid-strobe reset");
        tick();
        check_idle("held reset");
        rst = 1'b0;
        e = 0;
        mon = 1'b1;

        // R10, R5: first steps after reset restart the pointers with no strobe.
        run_to(D);
        n_chk++;
        if (int'(sample_c) >= 0 || fall[2] !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 phase 2 first step act=%0d/%0b exp=neg/0", sample_c, fall[2]);
        end
        run_to(140 * D);

        done = 1'b1;
        report();
        $finish;
    end
endmodule